// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether an incoming Ethernet frame is kept or dropped by examining only its 6-byte destination address. The address enters one byte per clock on a stream qualified by `byte_vld`, with a `sof` pulse that marks the first byte. While the bytes arrive, the block folds each one into a hash CRC and stores it. In the clock after the sixth byte it reports an accept/reject decision, a done strobe, a group-address flag and a receive status byte.

The checks are a promiscuous override, a broadcast check (all-ones address), a multicast check through a 64-entry hash mask, and an exact match against the station address for individual addresses. Each of the first three is gated by its own enable bit in a configuration byte. The configuration byte, the station address and the hash mask are read in the decision cycle itself, so the decision always reflects their values at that moment.

A small state machine drives the sequence. `ST_IDLE` waits for `sof`. `ST_ADDR` collects bytes. `ST_DECIDE` presents the result for exactly one clock. The transitions are:
- IDLE→ADDR on `sof`.
- ADDR→DECIDE when the sixth byte is taken.
- ADDR→ADDR (restart) on a new `sof`.
- DECIDE→IDLE when there is no `sof`.
- DECIDE→ADDR when `sof` arrives during the decision cycle.

Top module: `rx_dest_filter`

## Requirements
- R1: While reset is asserted and after its release, with no `sof`, `dec_done`, `dec_accept`, `dec_group` are 0 and `dec_status` is 8'h00.
- R2: A byte is taken only when `byte_vld` is 1 and either `sof` is 1 or a capture is in progress. The byte presented with `sof` is byte 0. Bytes presented outside a capture are ignored. A cycle with `byte_vld` low stalls the capture.
- R3: `dec_done` is high for exactly one clock, in the cycle after the sixth byte is taken. A `sof` during a capture discards the bytes taken so far and restarts the capture from byte 0.
- R4: When configuration bit 4 (promiscuous) is 1, every address is accepted.
- R5: An all-ones destination is broadcast and, without promiscuous, is accepted only when configuration bit 2 is 1.
- R6: A destination that is not broadcast and whose byte 0 has bit 0 set is multicast. Without promiscuous, it is accepted only when configuration bit 3 is 1 and the hash mask bit selected by its hash index is 1.
- R7: The hash CRC starts at 32'hFFFFFFFF. The bytes are taken in arrival order, each least significant bit first. For each bit, carry = crc[31] XOR data bit; then crc is shifted left one place and, if carry is 1, becomes (crc XOR 32'h04C11DB6) OR 1. The index is crc[31:26]. It selects mask byte index[5:3], bit index[2:0], which is `hash_mask[index]`.
- R8: Any other destination is accepted only when all six bytes equal the station address. Byte 0, the first received, is compared with `station_addr[7:0]`, and byte k with `station_addr[8k+7:8k]`.
- R9: During `dec_done`, `dec_group` equals bit 0 of byte 0. `dec_status` is 8'h01, ORed with 8'h20 when `dec_group` is 1, if the frame is accepted, and 8'h00 if it is rejected.
- R10: `cfg_rx`, `station_addr` and `hash_mask` are used only in the decision cycle. Changes made while the address is still arriving affect only the final decision.
- R11: A `sof` in the decision cycle does not alter the decision shown in that cycle, and it starts the next capture with its byte as byte 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof | input | 1 | Start-of-frame pulse, marks byte 0 |
| byte_vld | input | 1 | Address byte valid |
| byte_dat | input | 8 | Address byte |
| cfg_rx | input | 8 | Receive configuration: bit 2 broadcast enable, bit 3 multicast enable, bit 4 promiscuous |
| station_addr | input | 48 | Station address, byte 0 in bits 7:0 |
| hash_mask | input | 64 | Multicast hash mask, bit n selects hash index n |
| dec_done | output | 1 | Decision strobe, one clock |
| dec_accept | output | 1 | Frame accepted (valid with dec_done) |
| dec_group | output | 1 | Destination is a group address (valid with dec_done) |
| dec_status | output | 8 | Receive status byte (valid with dec_done) |

## Verification
The decision cycle for one frame can coincide with the `sof` and first byte of the next, so the result output and the capture restart share one clock. The bench provokes this by presenting the next frame's byte 0 together with `sof` in the decision cycle. It checks that the shown result still belongs to the earlier address and that the later frame's decision arrives exactly six taken bytes later with its own result. A second overlap is also exercised: a configuration or station change applied in the decision cycle, judged by whether the decision follows the new value.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ADDR   = 2'd1,
        ST_DECIDE = 2'd2
    } rxf_state_e;

    localparam int          HASH_CRC_W      = 32;
    localparam logic [31:0] HASH_POLY       = 32'h04C1_1DB6;
    localparam int          CFG_BCAST_BIT   = 2;
    localparam int          CFG_MCAST_BIT   = 3;
    localparam int          CFG_PROMISC_BIT = 4;
    localparam logic [7:0]  STAT_GOOD       = 8'h01;
    localparam logic [7:0]  STAT_GROUP      = 8'h20;

    // Fold one byte, LSB first, into the running hash register.
    function automatic logic [HASH_CRC_W-1:0] hash_fold_byte(
        input logic [HASH_CRC_W-1:0] crc_in,
        input logic [7:0]            data
    );
        logic [HASH_CRC_W-1:0] c;
        logic                  fb;
        c = crc_in;
        for (int b = 0; b < 8; b++) begin
            fb = c[HASH_CRC_W-1] ^ data[b];
            c  = {c[HASH_CRC_W-2:0], 1'b0};
            if (fb) begin
                c = (c ^ HASH_POLY) | {{(HASH_CRC_W-1){1'b0}}, 1'b1};
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/rxf_hash_crc.sv
module rxf_hash_crc
    import rxf_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             take,
    input  logic [7:0]       byte_dat,
    output logic [IDX_W-1:0] hash_idx
);

    logic [HASH_CRC_W-1:0] crc_q;
    logic [HASH_CRC_W-1:0] crc_base;

    always_comb begin
        crc_base = clr ? '1 : crc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '1;
        end else if (take) begin
            crc_q <= hash_fold_byte(crc_base, byte_dat);
        end else if (clr) begin
            crc_q <= '1;
        end
    end

    always_comb begin
        hash_idx = crc_q[HASH_CRC_W-1 -: IDX_W];
    end

    // R7
    crc_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !take) |=> (crc_q == '1));

    // R2
    crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !take) |=> $stable(crc_q));

endmodule

// File: rtl/rxf_addr_store.sv
module rxf_addr_store #(
    parameter int ADDR_BYTES = 6,
    parameter int CNT_W      = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take,
    input  logic [CNT_W-1:0]        byte_idx,
    input  logic [7:0]              byte_dat,
    input  logic [ADDR_BYTES*8-1:0] station_addr,
    output logic                    uc_hit,
    output logic                    dest_bcast,
    output logic                    dest_group
);

    logic [ADDR_BYTES*8-1:0] dest_q;

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_slot
        logic slot_we;
        always_comb begin
            slot_we = take && (byte_idx == CNT_W'(g));
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dest_q[g*8 +: 8] <= '0;
            end else if (slot_we) begin
                dest_q[g*8 +: 8] <= byte_dat;
            end
        end

        // R2
        slot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (take && byte_idx == CNT_W'(g)) |=> (dest_q[g*8 +: 8] == $past(byte_dat)));
    end

    always_comb begin
        uc_hit     = (dest_q == station_addr);
        dest_bcast = &dest_q;
        dest_group = dest_q[0];
    end

endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
    import rxf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int CNT_W      = 3,
    parameter int IDX_W      = 6,
    parameter int MASK_W     = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             byte_vld,
    input  logic [IDX_W-1:0] hash_idx,
    input  logic             uc_hit,
    input  logic             dest_bcast,
    input  logic             dest_group,
    input  logic [7:0]       cfg_rx,
    input  logic [MASK_W-1:0] hash_mask,
    output logic             clr,
    output logic             take,
    output logic [CNT_W-1:0] byte_idx,
    output logic             dec_done,
    output logic             dec_accept,
    output logic             dec_group,
    output logic [7:0]       dec_status
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_BYTES - 1);

    rxf_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             last_take;

    always_comb begin
        clr       = sof;
        take      = byte_vld && (sof || (state_q == ST_ADDR));
        byte_idx  = sof ? '0 : cnt_q;
        last_take = take && (byte_idx == LAST_IDX);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (last_take)      state_d = ST_DECIDE;
                else if (sof)       state_d = ST_ADDR;
            end
            ST_ADDR: begin
                if (last_take)      state_d = ST_DECIDE;
            end
            ST_DECIDE: begin
                if (last_take)      state_d = ST_DECIDE;
                else if (sof)       state_d = ST_ADDR;
                else                state_d = ST_IDLE;
            end
            default:                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                cnt_q <= last_take ? '0 : byte_idx + CNT_W'(1);
            end else if (sof) begin
                cnt_q <= '0;
            end
        end
    end

    always_comb begin
        dec_done   = 1'b0;
        dec_accept = 1'b0;
        dec_group  = 1'b0;
        dec_status = '0;
        if (state_q == ST_DECIDE) begin
            dec_done  = 1'b1;
            dec_group = dest_group;
            if (cfg_rx[CFG_PROMISC_BIT]) begin
                dec_accept = 1'b1;
            end else if (dest_bcast) begin
                dec_accept = cfg_rx[CFG_BCAST_BIT];
            end else if (dest_group) begin
                dec_accept = cfg_rx[CFG_MCAST_BIT] && hash_mask[hash_idx];
            end else begin
                dec_accept = uc_hit;
            end
            if (dec_accept) begin
                dec_status = STAT_GOOD | (dest_group ? STAT_GROUP : 8'h00);
            end
        end
    end

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_done && !sof) |=> !dec_done);

    // R3
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_take |=> dec_done);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !sof) |=> !dec_done);

    // R4
    promisc_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_done && cfg_rx[CFG_PROMISC_BIT]) |-> dec_accept);

    // R9
    reject_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_done && !dec_accept) |-> (dec_status == 8'h00));

    // R9
    group_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_done && dec_accept) |-> (dec_status[0] && (dec_status[5] == dest_group)));

    // R1
    quiet_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_done |-> (!dec_accept && !dec_group && dec_status == 8'h00));

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_IDX);

endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
    import rxf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int IDX_W      = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sof,
    input  logic                    byte_vld,
    input  logic [7:0]              byte_dat,
    input  logic [7:0]              cfg_rx,
    input  logic [ADDR_BYTES*8-1:0] station_addr,
    input  logic [(1<<IDX_W)-1:0]   hash_mask,
    output logic                    dec_done,
    output logic                    dec_accept,
    output logic                    dec_group,
    output logic [7:0]              dec_status
);

    localparam int CNT_W  = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam int MASK_W = 1 << IDX_W;

    logic             clr;
    logic             take;
    logic [CNT_W-1:0] byte_idx;
    logic [IDX_W-1:0] hash_idx;
    logic             uc_hit;
    logic             dest_bcast;
    logic             dest_group;

    rxf_ctrl #(
        .ADDR_BYTES (ADDR_BYTES),
        .CNT_W      (CNT_W),
        .IDX_W      (IDX_W),
        .MASK_W     (MASK_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sof        (sof),
        .byte_vld   (byte_vld),
        .hash_idx   (hash_idx),
        .uc_hit     (uc_hit),
        .dest_bcast (dest_bcast),
        .dest_group (dest_group),
        .cfg_rx     (cfg_rx),
        .hash_mask  (hash_mask),
        .clr        (clr),
        .take       (take),
        .byte_idx   (byte_idx),
        .dec_done   (dec_done),
        .dec_accept (dec_accept),
        .dec_group  (dec_group),
        .dec_status (dec_status)
    );

    rxf_hash_crc #(
        .IDX_W (IDX_W)
    ) u_hash (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .take     (take),
        .byte_dat (byte_dat),
        .hash_idx (hash_idx)
    );

    rxf_addr_store #(
        .ADDR_BYTES (ADDR_BYTES),
        .CNT_W      (CNT_W)
    ) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .take         (take),
        .byte_idx     (byte_idx),
        .byte_dat     (byte_dat),
        .station_addr (station_addr),
        .uc_hit       (uc_hit),
        .dest_bcast   (dest_bcast),
        .dest_group   (dest_group)
    );

endmodule

// File: tb/test_rx_dest_filter.sv
module test_rx_dest_filter;

    localparam time CLK_PERIOD = 10ns;
    localparam logic [47:0] STA = 48'h5634_1200_AB02;
    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] MC_A  = 48'h0100_5E00_0001;
    localparam logic [47:0] MC_B  = 48'h3333_0000_0033;

    // {mask_sel[1:0], cfg[7:0], dest[47:0]}; mask_sel: 0 none, 1 all, 2 only hit, 3 all but hit
    localparam logic [57:0] VEC [0:14] = '{
        {2'd0, 8'h00, STA},
        {2'd0, 8'h04, STA},
        {2'd1, 8'h0C, 48'h9634_1200_AB02},
        {2'd1, 8'h0C, 48'h5634_1200_AB04},
        {2'd0, 8'h04, BCAST},
        {2'd1, 8'h08, BCAST},
        {2'd0, 8'h10, BCAST},
        {2'd1, 8'h08, MC_A},
        {2'd0, 8'h08, MC_A},
        {2'd2, 8'h08, MC_A},
        {2'd3, 8'h08, MC_A},
        {2'd1, 8'h04, MC_A},
        {2'd2, 8'h08, MC_B},
        {2'd0, 8'h10, 48'h0000_0000_0010},
        {2'd0, 8'h10, MC_B}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_dat = '0;
    logic [7:0]  cfg_rx = '0;
    logic [47:0] station_addr = STA;
    logic [63:0] hash_mask = '0;
    logic        dec_done;
    logic        dec_accept;
    logic        dec_group;
    logic [7:0]  dec_status;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_dest_filter i_rx_dest_filter (
        .clk          (clk),
        .rst_n        (rst_n),
        .sof          (sof),
        .byte_vld     (byte_vld),
        .byte_dat     (byte_dat),
        .cfg_rx       (cfg_rx),
        .station_addr (station_addr),
        .hash_mask    (hash_mask),
        .dec_done     (dec_done),
        .dec_accept   (dec_accept),
        .dec_group    (dec_group),
        .dec_status   (dec_status)
    );

    // Hash index model: 48 address bits walked in arrival order, LSB of each byte first.
    function automatic logic [5:0] model_idx(input logic [47:0] d);
        logic [31:0] r = 32'hFFFF_FFFF;
        for (int k = 0; k < 48; k++) begin
            logic m;
            m = r[31] ^ d[k];
            r = r << 1;
            if (m) r = (r ^ 32'h04C1_1DB6) | 32'h1;
        end
        return r[31:26];
    endfunction

    function automatic logic [63:0] make_mask(input logic [1:0] sel, input logic [47:0] d);
        logic [63:0] one = 64'd1 << model_idx(d);
        case (sel)
            2'd0: return 64'd0;
            2'd1: return '1;
            2'd2: return one;
            default: return ~one;
        endcase
    endfunction

    function automatic logic model_accept(input logic [47:0] d, input logic [7:0] c,
                                          input logic [63:0] m, input logic [47:0] s);
        if (c[4]) return 1'b1;
        if (d == 48'hFFFF_FFFF_FFFF) return c[2];
        if (d[0]) return c[3] & m[model_idx(d)];
        return d == s;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drives bytes 0..5; returns in the cycle of byte 5, before its sampling edge.
    task automatic drive_addr(input logic [47:0] d);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            sof      = (i == 0);
            byte_vld = 1'b1;
            byte_dat = d[8*i +: 8];
        end
    endtask

    task automatic go_quiet();
        @(negedge clk);
        sof      = 1'b0;
        byte_vld = 1'b0;
    endtask

    // Called in the decision cycle after inputs for that cycle are set.
    task automatic expect_decision(input string req, input logic [47:0] d);
        logic acc;
        logic [7:0] st;
        #1;
        acc = model_accept(d, cfg_rx, hash_mask, station_addr);
        st  = acc ? (8'h01 | (d[0] ? 8'h20 : 8'h00)) : 8'h00;
        chk({req, " done"},   {15'd0, dec_done},   16'd1);
        chk({req, " accept"}, {15'd0, dec_accept}, {15'd0, acc});
        chk({req, " group"},  {15'd0, dec_group},  {15'd0, d[0]});
        chk({req, " status"}, {8'd0, dec_status},  {8'd0, st});
    endtask

    task automatic expect_no_done(input string req);
        #1;
        chk(req, {15'd0, dec_done}, 16'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset done",   {15'd0, dec_done},   16'd0);
        chk("R1 reset accept", {15'd0, dec_accept}, 16'd0);
        chk("R1 reset status", {8'd0, dec_status},  16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk("R1 idle after reset", {15'd0, dec_done}, 16'd0);

        // Table walk: R4 R5 R6 R7 R8 R9
        for (int v = 0; v < 15; v++) begin
            logic [47:0] d;
            d = VEC[v][47:0];
            @(negedge clk);
            cfg_rx    = VEC[v][55:48];
            hash_mask = make_mask(VEC[v][57:56], d);
            drive_addr(d);
            go_quiet();
            expect_decision("R4/R5/R6/R7/R8/R9 table", d);
            @(negedge clk);
            expect_no_done("R3 single pulse");
        end

        // R2: bytes without sof while idle are ignored
        cfg_rx = 8'h10;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            byte_vld = 1'b1;
            byte_dat = 8'hFF;
            expect_no_done("R2 idle bytes ignored");
        end
        go_quiet();
        expect_no_done("R2 idle bytes ignored tail");

        // R2: gaps stall the capture
        cfg_rx = 8'h00;
        station_addr = STA;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            sof      = (i == 0);
            byte_vld = 1'b1;
            byte_dat = STA[8*i +: 8];
            @(negedge clk);
            sof      = 1'b0;
            byte_vld = 1'b0;
            byte_dat = 8'h00;
            if (i == 5) expect_decision("R2 gapped capture", STA);
            else        expect_no_done("R2 gap stalls");
        end

        // R3: sof mid-capture restarts
        cfg_rx = 8'h04;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            sof      = (i == 0);
            byte_vld = 1'b1;
            byte_dat = 8'hFF;
        end
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            sof      = (i == 0);
            byte_vld = 1'b1;
            byte_dat = STA[8*i +: 8] ^ ((i == 2) ? 8'h01 : 8'h00);
            if (i == 3) expect_no_done("R3 restart no early done");
        end
        go_quiet();
        expect_decision("R3 restart uses new bytes", STA ^ 48'h0000_0001_0000);

        // R10: configuration changed in the decision cycle
        cfg_rx = 8'h00;
        hash_mask = '0;
        drive_addr(48'h0000_0000_0042);
        go_quiet();
        cfg_rx = 8'h10;
        expect_decision("R10 promisc set late", 48'h0000_0000_0042);
        cfg_rx = 8'h00;
        drive_addr(48'h0000_0000_0042);
        go_quiet();
        station_addr = 48'h0000_0000_0042;
        expect_decision("R10 station set late", 48'h0000_0000_0042);
        cfg_rx = 8'h08;
        drive_addr(MC_A);
        go_quiet();
        hash_mask = make_mask(2'd2, MC_A);
        expect_decision("R10 mask set late", MC_A);
        station_addr = STA;
        hash_mask = '0;

        // R11: next frame starts in the decision cycle
        cfg_rx = 8'h04;
        drive_addr(BCAST);
        @(negedge clk);
        sof      = 1'b1;
        byte_vld = 1'b1;
        byte_dat = STA[7:0];
        expect_decision("R11 overlap first", BCAST);
        for (int i = 1; i < 6; i++) begin
            @(negedge clk);
            sof      = 1'b0;
            byte_vld = 1'b1;
            byte_dat = STA[8*i +: 8];
            expect_no_done("R11 overlap capturing");
        end
        go_quiet();
        expect_decision("R11 overlap second", STA);
        @(negedge clk);
        expect_no_done("R11 overlap end");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule